// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Sequencer

This block is one DMA channel whose work is described by a small descriptor register file. The descriptor gives a source and a destination address, a signed step for each address, an access size and a circular-window size for each side, a byte count per service request, a beginning and a current iteration count, signed adjustments applied once a full run of iterations ends, and a set of control flags. Each service request runs one minor loop: a series of read-then-write pairs on a single request/ready memory port until the programmed byte count has been moved. The addresses are then updated and the current iteration count drops by one.

When the current count runs out, the major loop is complete. The engine applies the end-of-run address adjustments, reloads the current count from the beginning count and can raise an interrupt pulse, clear its own request enable and pulse a start request towards another channel. An optional half-way interrupt, links after each minor loop, signed offsets after each minor loop (taken from the byte-count word when the global mapping input is high) and throttling stalls between accesses complete the channel. Software programs the descriptor through a plain write port while the channel is idle.

Top module: `dma_tcd_engine`

## Requirements
- R1: After reset, memReq, busy, reqEnabled, irqMajor, irqHalf and linkValid are all 0.
- R2: A service request taken while reqEnabled is 1 runs one minor loop. Each access is a read at the source address followed by a write at the destination address, and the write data is the word just read. The byte count drops by the source access size after each pair, and the loop ends after the pair that brings it to zero or below. Size code 0 is 1 byte, 1 is 2 bytes and 2 is 4 bytes. The source size sits at attribute bits 10:8 and the destination size at bits 2:0, and memSize shows the size of the current access. After each pair, each address moves by its signed 16-bit offset, so an offset of 0 holds a fixed address.
- R3: A nonzero circular field m (source at attribute bits 15:11, destination at bits 7:3) confines the offset step to the low m address bits, so the address wraps inside an aligned window of 2^m bytes.
- R4: Each minor loop lowers the current iteration count by one. When it reaches zero, the signed 32-bit source and destination end-of-run adjustments are added to the addresses, and the count reloads from the beginning count.
- R5: When mapEnable is 1, byte-count word bit 31 enables a source offset and bit 30 enables a destination offset, both taken from the signed field in bits 29:10 and added after each minor loop. With either enabled, the byte count is bits 9:0.
- R6: Control bit 1 gives a one-cycle irqMajor pulse at major completion. Control bit 2 gives a one-cycle irqHalf pulse when the decremented count equals half of the beginning count, rounded down, and is nonzero.
- R7: With control bit 3 set, major completion clears reqEnabled, and service requests are then ignored until enSet is pulsed.
- R8: With control bit 5 set, major completion pulses linkValid for one cycle, with linkChannel taken from control bits 11:8.
- R9: When iteration-word bit 15 is set, the count is bits 8:0, and every minor loop except the last pulses linkValid with linkChannel taken from iteration bits 12:9.
- R10: Control bits 15:14 set the throttle between access pairs within one minor loop: codes 0 and 1 add no idle cycles, code 2 adds 4 and code 3 adds 8.
- R11: Descriptor writes (index 0 source address, 1 destination address, 2 offsets with the destination offset in the upper half, 3 attributes, 4 byte-count word, 5 source adjustment, 6 destination adjustment, 7 control word in the upper half and iteration word in the lower half) take effect only while busy is 0. Writes made while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Descriptor write strobe |
| cfgAddr | input | 3 | Descriptor word index |
| cfgData | input | 32 | Descriptor write data |
| mapEnable | input | 1 | Global enable for minor-loop offsets in the byte-count word |
| enSet | input | 1 | Sets the request enable |
| enClr | input | 1 | Clears the request enable |
| svcReq | input | 1 | Service request; starts one minor loop |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | ADDR_W | Access address |
| memSize | output | 3 | Access size code |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| memReady | input | 1 | Completes the current access |
| busy | output | 1 | A minor loop is in progress |
| reqEnabled | output | 1 | Channel request enable |
| irqMajor | output | 1 | Major-completion interrupt pulse |
| irqHalf | output | 1 | Half-way interrupt pulse |
| linkValid | output | 1 | Start pulse for a linked channel |
| linkChannel | output | 4 | Linked channel number |

## Verification
The hardest case to reach from the ports is a descriptor write that arrives in the middle of a minor loop. The write must be issued while busy is high, and its lack of effect only shows up on the next request. The bench starts a four-access minor loop, writes a new source address while the loop is still running, and then checks that the following request reads from the address the earlier progression predicts. Minor-loop links are exercised with a count field that stays small only if bit 15 limits the count to 9 bits. The major link channel then shows up after exactly two requests.

// File: rtl/dtd_pkg.sv
package dtd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_STALL, ST_FINISH
  } dtdState_t;

  typedef struct packed {
    logic startMinor;
    logic readDone;
    logic writeDone;
    logic finishMinor;
  } dtdStrobe_t;

  function automatic logic [2:0] sizeBytes(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd2;
      3'd2:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dtd_ctrl.sv
module dtd_ctrl
  import dtd_pkg::*;
#(
  parameter int THROTTLE_SHORT = 4,
  parameter int THROTTLE_LONG  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       svcReq,
  input  logic       reqEnabled,
  input  logic       memReady,
  input  logic       lastAccess,
  input  logic [1:0] throttle,
  output dtdStrobe_t stb,
  output logic       busy,
  output logic       memReq,
  output logic       memWe
);
  localparam int STALL_W = $clog2(THROTTLE_LONG + 1);

  dtdState_t stateQ;
  logic [STALL_W-1:0] stallQ;

  always_comb begin
    stb.startMinor  = (stateQ == ST_IDLE) && svcReq && reqEnabled;
    stb.readDone    = (stateQ == ST_READ) && memReady;
    stb.writeDone   = (stateQ == ST_WRITE) && memReady;
    stb.finishMinor = (stateQ == ST_FINISH);
  end

  assign busy   = (stateQ != ST_IDLE);
  assign memReq = (stateQ == ST_READ) || (stateQ == ST_WRITE);
  assign memWe  = (stateQ == ST_WRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stallQ <= '0;
    end else begin
      case (stateQ)
        ST_IDLE:  if (stb.startMinor) stateQ <= ST_READ;
        ST_READ:  if (memReady) stateQ <= ST_WRITE;
        ST_WRITE: if (memReady) begin
          if (lastAccess) stateQ <= ST_FINISH;
          else if (throttle[1]) begin
            stateQ <= ST_STALL;
            stallQ <= throttle[0] ? STALL_W'(THROTTLE_LONG) : STALL_W'(THROTTLE_SHORT);
          end else stateQ <= ST_READ;
        end
        ST_STALL: begin
          stallQ <= stallQ - 1'b1;
          if (stallQ <= STALL_W'(1)) stateQ <= ST_READ;
        end
        default:  stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtd_datapath.sv
module dtd_datapath
  import dtd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              mapEnable,
  input  logic              enSet,
  input  logic              enClr,
  input  dtdStrobe_t        stb,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [2:0]        srcSize,
  output logic [2:0]        dstSize,
  output logic [31:0]       wdata,
  output logic              lastAccess,
  output logic [1:0]        throttle,
  output logic              reqEnabled,
  output logic              irqMajor,
  output logic              irqHalf,
  output logic              linkValid,
  output logic [3:0]        linkChannel
);
  logic [ADDR_W-1:0] srcAddrQ, dstAddrQ;
  logic [15:0] srcOffQ, dstOffQ, attrQ, biterQ;
  logic [31:0] nbytesQ, srcLastQ, dstLastQ, remainQ, dataQ;
  logic [14:0] citerQ;
  logic        intMajQ, intHalfQ, disableQ, majLinkQ, reqEnQ;
  logic [3:0]  majChQ;
  logic [1:0]  throttleQ;

  logic        srcLoopOff, dstLoopOff, minorLink, majorDone;
  logic [31:0] minorCount;
  logic [14:0] beginCnt, citerDec;
  logic [2:0]  stepBytes;
  logic [ADDR_W-1:0] loopOffExt;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] d,
                                                 input logic [4:0] m);
    logic [ADDR_W-1:0] mask;
    mask = (m == 5'd0) ? '1 : ((ADDR_W'(1) << m) - 1'b1);
    return (a & ~mask) | ((a + d) & mask);
  endfunction

  always_comb begin
    srcSize    = attrQ[10:8];
    dstSize    = attrQ[2:0];
    stepBytes  = sizeBytes(srcSize);
    srcLoopOff = mapEnable && nbytesQ[31];
    dstLoopOff = mapEnable && nbytesQ[30];
    loopOffExt = ADDR_W'($signed(nbytesQ[29:10]));
    if (!mapEnable)                minorCount = nbytesQ;
    else if (nbytesQ[31] || nbytesQ[30]) minorCount = {22'd0, nbytesQ[9:0]};
    else                           minorCount = {2'd0, nbytesQ[29:0]};
    minorLink  = biterQ[15];
    beginCnt   = minorLink ? {6'd0, biterQ[8:0]} : biterQ[14:0];
    citerDec   = citerQ - 1'b1;
    majorDone  = (citerQ <= 15'd1);
    lastAccess = (remainQ <= 32'(stepBytes));
  end

  assign srcAddr    = srcAddrQ;
  assign dstAddr    = dstAddrQ;
  assign wdata      = dataQ;
  assign throttle   = throttleQ;
  assign reqEnabled = reqEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddrQ <= '0; dstAddrQ <= '0;
      srcOffQ <= '0; dstOffQ <= '0; attrQ <= '0; biterQ <= '0;
      nbytesQ <= '0; srcLastQ <= '0; dstLastQ <= '0;
      remainQ <= '0; dataQ <= '0; citerQ <= '0;
      intMajQ <= 1'b0; intHalfQ <= 1'b0; disableQ <= 1'b0; majLinkQ <= 1'b0;
      majChQ <= '0; throttleQ <= '0; reqEnQ <= 1'b0;
      irqMajor <= 1'b0; irqHalf <= 1'b0; linkValid <= 1'b0; linkChannel <= '0;
    end else begin
      irqMajor  <= 1'b0;
      irqHalf   <= 1'b0;
      linkValid <= 1'b0;
      if (enSet) reqEnQ <= 1'b1;
      if (enClr) reqEnQ <= 1'b0;
      if (cfgWe) begin
        case (cfgAddr)
          3'd0: srcAddrQ <= ADDR_W'(cfgData);
          3'd1: dstAddrQ <= ADDR_W'(cfgData);
          3'd2: begin srcOffQ <= cfgData[15:0]; dstOffQ <= cfgData[31:16]; end
          3'd3: attrQ <= cfgData[15:0];
          3'd4: nbytesQ <= cfgData;
          3'd5: srcLastQ <= cfgData;
          3'd6: dstLastQ <= cfgData;
          default: begin
            biterQ    <= cfgData[15:0];
            citerQ    <= cfgData[15] ? {6'd0, cfgData[8:0]} : cfgData[14:0];
            intMajQ   <= cfgData[17];
            intHalfQ  <= cfgData[18];
            disableQ  <= cfgData[19];
            majLinkQ  <= cfgData[21];
            majChQ    <= cfgData[27:24];
            throttleQ <= cfgData[31:30];
          end
        endcase
      end
      if (stb.startMinor) remainQ <= minorCount;
      if (stb.readDone)   dataQ <= memRdata;
      if (stb.writeDone) begin
        srcAddrQ <= stepAddr(srcAddrQ, ADDR_W'($signed(srcOffQ)), attrQ[15:11]);
        dstAddrQ <= stepAddr(dstAddrQ, ADDR_W'($signed(dstOffQ)), attrQ[7:3]);
        remainQ  <= remainQ - 32'(stepBytes);
      end
      if (stb.finishMinor) begin
        srcAddrQ <= srcAddrQ + (srcLoopOff ? loopOffExt : '0)
                             + (majorDone ? ADDR_W'($signed(srcLastQ)) : '0);
        dstAddrQ <= dstAddrQ + (dstLoopOff ? loopOffExt : '0)
                             + (majorDone ? ADDR_W'($signed(dstLastQ)) : '0);
        citerQ   <= majorDone ? beginCnt : citerDec;
        irqMajor <= majorDone && intMajQ;
        irqHalf  <= intHalfQ && !majorDone && (citerDec == (beginCnt >> 1));
        if (majorDone) begin
          linkValid   <= majLinkQ;
          linkChannel <= majChQ;
          if (disableQ) reqEnQ <= 1'b0;
        end else begin
          linkValid   <= minorLink;
          linkChannel <= biterQ[12:9];
        end
      end
    end
  end
endmodule

// File: rtl/dma_tcd_engine.sv
module dma_tcd_engine
  import dtd_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int THROTTLE_SHORT = 4,
  parameter int THROTTLE_LONG  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [31:0]       cfgData,
  input  logic              mapEnable,
  input  logic              enSet,
  input  logic              enClr,
  input  logic              svcReq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady,
  output logic              busy,
  output logic              reqEnabled,
  output logic              irqMajor,
  output logic              irqHalf,
  output logic              linkValid,
  output logic [3:0]        linkChannel
);
  dtdStrobe_t stb;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [2:0] srcSize, dstSize;
  logic lastAccess;
  logic [1:0] throttle;

  dtd_ctrl #(.THROTTLE_SHORT(THROTTLE_SHORT), .THROTTLE_LONG(THROTTLE_LONG)) uCtrl (
    .clk(clk), .rstN(rstN), .svcReq(svcReq), .reqEnabled(reqEnabled),
    .memReady(memReady), .lastAccess(lastAccess), .throttle(throttle),
    .stb(stb), .busy(busy), .memReq(memReq), .memWe(memWe)
  );

  dtd_datapath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe && !busy), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .mapEnable(mapEnable), .enSet(enSet), .enClr(enClr),
    .stb(stb), .memRdata(memRdata), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .srcSize(srcSize), .dstSize(dstSize), .wdata(memWdata),
    .lastAccess(lastAccess), .throttle(throttle), .reqEnabled(reqEnabled),
    .irqMajor(irqMajor), .irqHalf(irqHalf), .linkValid(linkValid),
    .linkChannel(linkChannel)
  );

  assign memAddr = memWe ? dstAddr : srcAddr;
  assign memSize = memWe ? dstSize : srcSize;
endmodule

// File: rtl/dtd_checker.sv
module dtd_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              reqEnabled,
  input logic              irqMajor,
  input logic              linkValid
);
  // R2: a finished read is followed at once by its write
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && !memWe) |=> (memReq && memWe));
  // R2: a pending access keeps its address until accepted
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));
  // R7: a disabled idle channel stays idle
  a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !reqEnabled) |=> !busy);
  // R6: the major interrupt appears once the loop has ended
  a_r6_irq_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    irqMajor |-> !busy);
  // R8: link requests are single-cycle pulses
  a_r8_link_pulse: assert property (@(posedge clk) disable iff (!rstN)
    linkValid |=> !linkValid);
endmodule

bind dma_tcd_engine dtd_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memReady(memReady),
  .memAddr(memAddr), .busy(busy), .reqEnabled(reqEnabled),
  .irqMajor(irqMajor), .linkValid(linkValid)
);

// File: tb/dma_tcd_engine_test.sv
module dma_tcd_engine_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0, mapEnable = 1'b0, enSet = 1'b0, enClr = 1'b0, svcReq = 1'b0;
  logic [2:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic memReq, memWe, memReady = 1'b0, busy, reqEnabled;
  logic irqMajor, irqHalf, linkValid;
  logic [3:0] linkChannel;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [2:0] memSize;

  int tests = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] logAddr [256];
  logic       logWe [256];
  logic [2:0] logSize [256];
  int logN = 0, majorCnt = 0, halfCnt = 0, linkCnt = 0, idleCnt = 0;
  logic [3:0] lastLinkCh = '0;

  always #5 clk = ~clk;

  dma_tcd_engine uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .mapEnable(mapEnable), .enSet(enSet), .enClr(enClr), .svcReq(svcReq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady), .busy(busy),
    .reqEnabled(reqEnabled), .irqMajor(irqMajor), .irqHalf(irqHalf),
    .linkValid(linkValid), .linkChannel(linkChannel)
  );

  assign memRdata = {mem[8'(memAddr + 3)], mem[8'(memAddr + 2)],
                     mem[8'(memAddr + 1)], mem[memAddr[7:0]]};

  always @(posedge clk) memReady <= memReq && !memReady;

  always @(negedge clk) begin
    if (memReq && memReady) begin
      logAddr[logN % 256] = memAddr[7:0];
      logWe[logN % 256]   = memWe;
      logSize[logN % 256] = memSize;
      logN = logN + 1;
      if (memWe) begin
        mem[memAddr[7:0]] = memWdata[7:0];
        if (memSize >= 3'd1) mem[8'(memAddr + 1)] = memWdata[15:8];
        if (memSize == 3'd2) begin
          mem[8'(memAddr + 2)] = memWdata[23:16];
          mem[8'(memAddr + 3)] = memWdata[31:24];
        end
      end
    end
    if (irqMajor) majorCnt = majorCnt + 1;
    if (irqHalf) halfCnt = halfCnt + 1;
    if (linkValid) begin linkCnt = linkCnt + 1; lastLinkCh = linkChannel; end
    if (busy && !memReq) idleCnt = idleCnt + 1;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic pulseEnSet();
    @(negedge clk); enSet = 1'b1;
    @(negedge clk); enSet = 1'b0;
  endtask

  task automatic doReq();
    @(negedge clk); svcReq = 1'b1;
    @(negedge clk); svcReq = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] s, d, offs, attr, nb, sl, dl, ci);
    cfg(3'd0, s); cfg(3'd1, d); cfg(3'd2, offs); cfg(3'd3, attr);
    cfg(3'd4, nb); cfg(3'd5, sl); cfg(3'd6, dl); cfg(3'd7, ci);
  endtask

  task automatic testReset();
    check("R1", "memReq", 32'(memReq), 0);
    check("R1", "busy", 32'(busy), 0);
    check("R1", "reqEnabled", 32'(reqEnabled), 0);
    check("R1", "irq/link", {29'd0, irqMajor, irqHalf, linkValid}, 0);
  endtask

  task automatic testByteBuffer();
    int b, m0, h0;
    setup(32'h10, 32'h80, {16'd1, 16'd1}, 32'h0, 32'd1,
          32'hFFFF_FFFC, 32'hFFFF_FFFC, {16'h000E, 16'd4});
    pulseEnSet();
    m0 = majorCnt; h0 = halfCnt;
    for (int k = 0; k < 4; k++) begin
      b = logN;
      doReq();
      check("R2", "accesses per request", logN - b, 2);
      check("R2", "read addr", {24'd0, logAddr[b % 256]}, 32'h10 + k);
      check("R2", "read first", 32'(logWe[b % 256]), 0);
      check("R2", "write addr", {24'd0, logAddr[(b + 1) % 256]}, 32'h80 + k);
      if (k == 1) check("R6", "half irq", halfCnt - h0, 1);
    end
    check("R6", "major irq", majorCnt - m0, 1);
    check("R6", "half irq once", halfCnt - h0, 1);
    check("R7", "enable cleared", 32'(reqEnabled), 0);
    for (int i = 0; i < 4; i++)
      check("R2", "copied byte", {24'd0, mem[8'h80 + i]}, {24'd0, mem[8'h10 + i]});
    b = logN;
    doReq();
    check("R7", "request ignored when disabled", logN - b, 0);
    pulseEnSet();
    b = logN;
    doReq();
    check("R4", "src after end adjust", {24'd0, logAddr[b % 256]}, 32'h10);
    check("R4", "dst after end adjust", {24'd0, logAddr[(b + 1) % 256]}, 32'h80);
  endtask

  task automatic testWideFixed();
    int b;
    setup(32'h30, 32'hC0, {16'd0, 16'd4}, 32'h0202, 32'd8,
          32'hFFFF_FFF8, 32'h0, {16'h0000, 16'd1});
    b = logN;
    doReq();
    check("R2", "wide accesses", logN - b, 4);
    check("R2", "size code 2", 32'(logSize[b % 256]), 2);
    check("R2", "second read", {24'd0, logAddr[(b + 2) % 256]}, 32'h34);
    check("R2", "fixed dst", {24'd0, logAddr[(b + 3) % 256]}, 32'hC0);
    check("R2", "last word", {mem[8'hC3], mem[8'hC2], mem[8'hC1], mem[8'hC0]},
          {mem[8'h37], mem[8'h36], mem[8'h35], mem[8'h34]});
    b = logN;
    doReq();
    check("R4", "reload iter 1 and adjust", {24'd0, logAddr[b % 256]}, 32'h30);
  endtask

  task automatic testModulo();
    int b;
    logic [7:0] expS [3];
    expS[0] = 8'h20; expS[1] = 8'h24; expS[2] = 8'h20;
    setup(32'h20, 32'hA0, {16'd4, 16'd4}, 32'h1A02, 32'd4, 32'h0, 32'h0, {16'h0, 16'd3});
    for (int k = 0; k < 3; k++) begin
      b = logN;
      doReq();
      check("R3", "circular src", {24'd0, logAddr[b % 256]}, {24'd0, expS[k]});
      check("R3", "linear dst", {24'd0, logAddr[(b + 1) % 256]}, 32'hA0 + 4 * k);
    end
  endtask

  task automatic testLoopOffset();
    int b;
    @(negedge clk); mapEnable = 1'b1;
    setup(32'h40, 32'h90, {16'd1, 16'd1}, 32'h0, 32'hBFFF_F802, 32'h0, 32'h0, {16'h0, 16'd4});
    for (int k = 0; k < 2; k++) begin
      b = logN;
      doReq();
      check("R5", "count from low bits", logN - b, 4);
      check("R5", "src rewound", {24'd0, logAddr[b % 256]}, 32'h40);
      check("R5", "src second", {24'd0, logAddr[(b + 2) % 256]}, 32'h41);
      check("R5", "dst keeps going", {24'd0, logAddr[(b + 1) % 256]}, 32'h90 + 2 * k);
    end
    @(negedge clk); mapEnable = 1'b0;
  endtask

  task automatic testLinks();
    int l0;
    setup(32'h50, 32'hD0, {16'd1, 16'd1}, 32'h0, 32'd1, 32'h0, 32'h0, {16'h0520, 16'h8602});
    l0 = linkCnt;
    doReq();
    check("R9", "minor link pulse", linkCnt - l0, 1);
    check("R9", "minor link channel", 32'(lastLinkCh), 3);
    doReq();
    check("R8", "major link pulse", linkCnt - l0, 2);
    check("R8", "major link channel", 32'(lastLinkCh), 5);
  endtask

  task automatic testThrottle();
    int i0;
    logic [15:0] codes [3];
    int expIdle [3];
    codes[0] = 16'h8000; codes[1] = 16'hC000; codes[2] = 16'h0000;
    expIdle[0] = 5; expIdle[1] = 9; expIdle[2] = 1;
    for (int k = 0; k < 3; k++) begin
      setup(32'h60, 32'hE0, {16'd1, 16'd1}, 32'h0, 32'd2, 32'h0, 32'h0, {codes[k], 16'd1});
      i0 = idleCnt;
      doReq();
      check("R10", "idle cycles in minor loop", idleCnt - i0, expIdle[k]);
    end
  endtask

  task automatic testBusyWrite();
    int b;
    setup(32'h70, 32'hF0, {16'd1, 16'd1}, 32'h0, 32'd4, 32'h0, 32'h0, {16'h0, 16'd3});
    @(negedge clk); svcReq = 1'b1;
    @(negedge clk); svcReq = 1'b0;
    check("R11", "busy during write", 32'(busy), 1);
    cfg(3'd0, 32'hEE);
    while (busy) @(negedge clk);
    @(negedge clk);
    b = logN;
    doReq();
    check("R11", "busy write ignored", {24'd0, logAddr[b % 256]}, 32'h74);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testByteBuffer();
    testWideFixed();
    testModulo();
    testLoopOffset();
    testLinks();
    testThrottle();
    testBusyWrite();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule